// File: doc/BRIEF.md
# Keyed Software Watchdog Timer

This block guards a processor against software that has stopped making progress. A timeout counter starts running as soon as reset is released, with no set-up needed. Software must restart it from time to time by writing a two-word key sequence to a service port. If the counter runs out first, the block raises a one-cycle request on one of two outputs: a system reset request or a non-maskable interrupt request. A configuration bit picks which of the two is used.

A configuration port sets the enable, the reset/interrupt select and the timeout length. It takes exactly one write per reset, and every later write is ignored. The clock is divided by a fixed prescaler of `DIV` cycles. The timeout counter then counts `period + 1` prescaled ticks. A timeout therefore takes `(period + 1) * DIV` clock cycles, measured from reset release, from the last completed service, or from the accepted configuration write. After each expiry the counter reloads and keeps running.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the watchdog is enabled, selects reset, and uses period `RELOAD`. With no further input, `rst_req` goes high after exactly `(RELOAD+1)*DIV` clock edges, counted from the first edge after reset release. Both outputs are low during and right after reset.
- R2: Writing 0x556C and then, on a later service write, 0xAA39 restarts the timeout. The next expiry then comes `(period+1)*DIV` edges after the 0xAA39 write. A service completed on the same edge as an expiry suppresses that expiry.
- R3: A service write of any value other than 0x556C or 0xAA39 discards a pending 0x556C. A 0xAA39 that follows it does not restart the timeout.
- R4: A 0xAA39 written with no pending 0x556C has no effect on the timeout.
- R5: A repeated 0x556C keeps the checker armed, so the next 0xAA39 completes the service.
- R6: On expiry, select value 0 (`cfg_nmi`=0) pulses `rst_req` and select value 1 pulses `nmi_req`. The two never pulse together.
- R7: When the accepted configuration has enable 0, neither output ever pulses.
- R8: Only the first configuration write after reset is accepted. Later writes change neither the enable, the select or the period, and they do not restart the timeout.
- R9: Each expiry pulse lasts exactly one cycle. The counter then reloads and the next expiry follows `(period+1)*DIV` edges later.
- R10: The accepted configuration write restarts the timeout with the newly written period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable value to write |
| cfg_nmi | input | 1 | Expiry action to write: 0 reset request, 1 interrupt request |
| cfg_period | input | CNT_W | Timeout length to write, in prescaled ticks minus one |
| svc_we | input | 1 | Service write strobe |
| svc_data | input | 16 | Service word |
| rst_req | output | 1 | One-cycle reset request on expiry |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request on expiry |

## Verification
The key checker is tried with four service patterns, each of which the next expiry time tells apart:
- the clean pair;
- the pair broken by a foreign word;
- a lone 0xAA39;
- a doubled 0x556C.

The configuration is tried with a first write that switches to the interrupt and shortens the period, a second write that tries to reverse it, and a disabling first write followed by an attempt to re-enable. Seeded random service and configuration traffic, mostly made of key words, is compared cycle by cycle with a bench model. This traffic reaches the cases where a service and an expiry fall on the same edge, where several writes run back to back, and where the period is zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [15:0] KEY_ARM  = 16'h556C;
  localparam logic [15:0] KEY_FIRE = 16'hAA39;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre <= '0;
    end else if (run) begin
      pre <= (pre == LAST) ? '0 : pre + PW'(1);
    end
  end

  assign tick = run && (pre == LAST);
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [15:0] data,
  output logic        done
);
  seq_t state;

  assign done = wr && (data == KEY_FIRE) && (state == SEQ_ARMED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
    end else if (wr) begin
      state <= (data == KEY_ARM) ? SEQ_ARMED : SEQ_IDLE;
    end
  end
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg #(
  parameter int              CW     = 16,
  parameter logic [CW-1:0]   RELOAD = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          en_in,
  input  logic          sel_in,
  input  logic [CW-1:0] per_in,
  output logic          accept,
  output logic          en,
  output logic          sel,
  output logic [CW-1:0] per
);
  logic locked;

  assign accept = we && !locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      en     <= 1'b1;
      sel    <= 1'b0;
      per    <= RELOAD;
    end else if (accept) begin
      locked <= 1'b1;
      en     <= en_in;
      sel    <= sel_in;
      per    <= per_in;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int            CW     = 16,
  parameter logic [CW-1:0] RELOAD = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] restart_val,
  input  logic [CW-1:0] reload_val,
  input  logic          sel,
  output logic          rst_req,
  output logic          nmi_req
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= RELOAD;
      rst_req <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      nmi_req <= 1'b0;
      if (restart) begin
        cnt <= restart_val;
      end else if (tick) begin
        if (cnt == '0) begin
          cnt     <= reload_val;
          rst_req <= !sel;
          nmi_req <= sel;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int               CNT_W  = 16,
  parameter int               DIV    = 4,
  parameter logic [CNT_W-1:0] RELOAD = CNT_W'(20)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic             cfg_nmi,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic             svc_we,
  input  logic [15:0]      svc_data,
  output logic             rst_req,
  output logic             nmi_req
);
  logic             cfg_accept;
  logic             en_q;
  logic             sel_q;
  logic [CNT_W-1:0] per_q;
  logic             svc_done;
  logic             restart;
  logic [CNT_W-1:0] restart_val;
  logic             tick;

  wdog_cfg #(.CW(CNT_W), .RELOAD(RELOAD)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .en_in  (cfg_en),
    .sel_in (cfg_nmi),
    .per_in (cfg_period),
    .accept (cfg_accept),
    .en     (en_q),
    .sel    (sel_q),
    .per    (per_q)
  );

  wdog_keyseq u_seq (
    .clk  (clk),
    .rst  (rst),
    .wr   (svc_we),
    .data (svc_data),
    .done (svc_done)
  );

  assign restart     = cfg_accept || svc_done;
  assign restart_val = cfg_accept ? cfg_period : per_q;

  wdog_prescale #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (en_q),
    .clr  (restart),
    .tick (tick)
  );

  wdog_timer #(.CW(CNT_W), .RELOAD(RELOAD)) u_tmr (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .restart     (restart),
    .restart_val (restart_val),
    .reload_val  (per_q),
    .sel         (sel_q),
    .rst_req     (rst_req),
    .nmi_req     (nmi_req)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          rst_req,
  input  logic          nmi_req,
  input  logic          en_q,
  input  logic          sel_q,
  input  logic [CW-1:0] per_q,
  input  logic          svc_done
);
  logic seen_cfg;

  always_ff @(posedge clk) begin
    if (rst) seen_cfg <= 1'b0;
    else if (cfg_we) seen_cfg <= 1'b1;
  end

  assert_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && nmi_req));

  assert_rst_sel_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(!sel_q));

  assert_nmi_sel_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_req) |-> $past(sel_q));

  assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  assert_nmi_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    nmi_req |=> !nmi_req);

  assert_svc_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    svc_done |=> !rst_req && !nmi_req);

  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !rst_req && !nmi_req);

  assert_lock_R8: assert property (@(posedge clk) disable iff (rst)
    seen_cfg |=> $stable(en_q) && $stable(sel_q) && $stable(per_q));
endmodule

bind keyed_wdog wdog_chk #(.CW(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .rst_req  (rst_req),
  .nmi_req  (nmi_req),
  .en_q     (en_q),
  .sel_q    (sel_q),
  .per_q    (per_q),
  .svc_done (svc_done)
);

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int RELOAD     = 20;
  localparam logic [15:0] K1 = 16'h556C;
  localparam logic [15:0] K2 = 16'hAA39;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_en = 1'b0, cfg_nmi = 1'b0;
  logic [15:0] cfg_period = '0;
  logic        svc_we = 1'b0;
  logic [15:0] svc_data = '0;
  logic        rst_req, nmi_req;

  int nchk = 0, nerr = 0, cyc = 0;
  string phase = "R1";

  // bench model state
  logic m_en, m_sel, m_lock, m_arm, ok;
  int   m_per, m_rem;
  logic exp_rst = 1'b0, exp_nmi = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdog #(.CNT_W(16), .DIV(DIV), .RELOAD(16'(RELOAD))) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_nmi(cfg_nmi),
    .cfg_period(cfg_period), .svc_we(svc_we), .svc_data(svc_data),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );

  function automatic int span(input int p);
    return (p + 1) * DIV;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 1; m_sel = 0; m_per = RELOAD; m_lock = 0; m_arm = 0;
      m_rem = span(RELOAD); exp_rst = 0; exp_nmi = 0;
    end else begin
      ok = svc_we && (svc_data == K2) && m_arm;
      if (svc_we) m_arm = (svc_data == K1);
      exp_rst = 0; exp_nmi = 0;
      if (cfg_we && !m_lock) begin
        m_en = cfg_en; m_sel = cfg_nmi; m_per = int'(cfg_period); m_lock = 1;
        m_rem = span(m_per);
      end else if (ok) begin
        m_rem = span(m_per);
      end else if (m_en) begin
        m_rem--;
        if (m_rem == 0) begin
          if (m_sel) exp_nmi = 1; else exp_rst = 1;
          m_rem = span(m_per);
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    nchk++;
    if (rst_req !== exp_rst || nmi_req !== exp_nmi) begin
      nerr++;
      $display("FAIL %s cycle %0d: actual rst/nmi=%b%b expected=%b%b",
               phase, cyc, rst_req, nmi_req, exp_rst, exp_nmi);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    svc_we = 0; cfg_we = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    cyc = 0;
  endtask

  task automatic svc(input logic [15:0] v);
    svc_we = 1; svc_data = v;
    tick();
    svc_we = 0;
  endtask

  task automatic cfg(input logic e, input logic s, input logic [15:0] p);
    cfg_we = 1; cfg_en = e; cfg_nmi = s; cfg_period = p;
    tick();
    cfg_we = 0;
  endtask

  task automatic wait_pulse(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      tick();
      if (rst_req || nmi_req) begin at = cyc; break; end
    end
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (rst_req || nmi_req) cnt++;
    end
  endtask

  initial begin
    int at, cnt;
    void'($urandom(32'h5EED_0042));

    // R1 reset state and first expiry
    phase = "R1";
    do_reset();
    check("R1 rst_req at reset", rst_req, 0);
    check("R1 nmi_req at reset", nmi_req, 0);
    wait_pulse(400, at);
    check("R1 first expiry cycle", at, span(RELOAD));
    check("R1 expiry selects reset", rst_req, 1);
    // R9 single-cycle pulse and periodic reload
    phase = "R9";
    tick();
    check("R9 pulse width", rst_req, 0);
    wait_pulse(400, at);
    check("R9 second expiry cycle", at, 2 * span(RELOAD));

    // R2 regular servicing prevents expiry
    phase = "R2";
    do_reset();
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      int c;
      count_pulses(30, c); cnt += c;
      svc(K1); svc(K2);
    end
    check("R2 no expiry while serviced", cnt, 0);
    wait_pulse(400, at);
    check("R2 expiry after last service", at, 8 * 32 + span(RELOAD));

    // R3 foreign word breaks the pair
    phase = "R3";
    do_reset();
    idle(10); svc(K1); svc(16'h1234); svc(K2);
    wait_pulse(400, at);
    check("R3 broken pair does not service", at, span(RELOAD));

    // R4 lone second key
    phase = "R4";
    do_reset();
    idle(10); svc(K2);
    wait_pulse(400, at);
    check("R4 lone 0xAA39 ignored", at, span(RELOAD));

    // R5 doubled first key
    phase = "R5";
    do_reset();
    idle(10); svc(K1); svc(K1); svc(K2);
    wait_pulse(400, at);
    check("R5 doubled 0x556C still services", at, 13 + span(RELOAD));

    // R6 / R10 interrupt select with new period
    phase = "R6 R10";
    do_reset();
    idle(5); cfg(1'b1, 1'b1, 16'd5);
    wait_pulse(400, at);
    check("R10 restart with new period", at, 6 + span(5));
    check("R6 nmi_req on expiry", nmi_req, 1);
    check("R6 rst_req stays low", rst_req, 0);

    // R8 second write ignored, no restart
    phase = "R8";
    cfg(1'b0, 1'b0, 16'd2);
    wait_pulse(400, at);
    check("R8 later write ignored", at, 30 + span(5));
    check("R8 select kept", nmi_req, 1);

    // R7 disabled watchdog stays quiet, re-enable refused
    phase = "R7";
    do_reset();
    cfg(1'b0, 1'b0, 16'd1);
    count_pulses(300, cnt);
    check("R7 disabled no expiry", cnt, 0);
    phase = "R8";
    cfg(1'b1, 1'b0, 16'd1);
    count_pulses(200, cnt);
    check("R8 re-enable refused", cnt, 0);

    // random traffic: R2 R3 R4 R5 R6 R9 R10
    phase = "random R2 R3 R4 R5 R6 R9 R10";
    for (int r = 0; r < 4; r++) begin
      int cfg_at;
      do_reset();
      cfg_at = int'($urandom_range(0, 200));
      for (int i = 0; i < 3000; i++) begin
        int pick;
        cfg_we = (i == cfg_at) || ($urandom_range(0, 255) == 0);
        cfg_en = ($urandom_range(0, 7) != 0);
        cfg_nmi = 1'($urandom_range(0, 1));
        cfg_period = 16'($urandom_range(0, 15));
        svc_we = ($urandom_range(0, 7) == 0);
        pick = int'($urandom_range(0, 19));
        svc_data = (pick < 9) ? K1 : (pick < 18) ? K2 : 16'($urandom);
        tick();
      end
      cfg_we = 0; svc_we = 0;
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog R1: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule